// File: doc/BRIEF.md
# Code-Domain Classifier with Return Guard

This block sits beside the decode stage of a processor pipeline and sorts every memory-access and control-transfer instruction into one of three domains. The domains are kernel code, trusted user code and untrusted user code. Trust is decided only by comparing the instruction's PC against a code range that kernel software loads. User code inside that range is trusted. All other user code is untrusted.

The block also guards the way untrusted code may leave. A control transfer from trusted code into untrusted code records the caller's link address in a single return register. From then on, the only control transfer untrusted code may make is to that address. Any other target raises a control-flow fault with a fixed cause code. A correct return raises a one-cycle pulse that other logic uses to clear its per-call data-bounds state, and it empties the return register. Only one level of untrusted call is tracked.

Classification, fault and pulse are combinational on the presented instruction. The range and the return register update on the rising clock edge.

Top module: `code_domain_guard`

## Requirements
- R1: After reset the trusted range is empty and the return register is invalid, so every checked user-mode instruction is classified as untrusted whatever its PC.
- R2: When `instValid` is low or `instClass` is 2'b00 (other), all three domain outputs, `cfFault` and `retPulse` are low.
- R3: A checked instruction (class 2'b01 load, 2'b10 store, 2'b11 branch/jump) issued with `privKernel` high asserts only `domKernel`, never faults and never pulses, whatever its target.
- R4: A checked user-mode instruction asserts `domTrusted` when start <= PC < end of the loaded range, and `domUntrusted` otherwise. Exactly one domain output is high for any checked instruction.
- R5: A range write (`rangeWrEn`) takes effect at the next edge only if `privKernel` is high in the same cycle. Otherwise the range is unchanged.
- R6: A trusted branch/jump whose target lies outside the trusted range stores `linkAddr` as the valid return address. A trusted branch/jump whose target lies inside the range stores nothing.
- R7: An untrusted branch/jump whose target equals the valid stored return address asserts `retPulse` in that cycle without a fault, and leaves the return register invalid after the edge.
- R8: An untrusted branch/jump whose target differs from the stored return address, or that is issued while the register is invalid, asserts `cfFault` with `cfCause` = 4'hE in that cycle and leaves the return register unchanged. Untrusted code never writes it, so calls do not nest.
- R9: An untrusted load or store raises neither `cfFault` nor `retPulse`. `cfCause` is 4'h0 whenever `cfFault` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instValid | input | 1 | Decoded instruction present |
| instPc | input | ADDR_W | PC of the instruction |
| privKernel | input | 1 | Instruction runs at kernel privilege |
| instClass | input | 2 | 00 other, 01 load, 10 store, 11 branch/jump |
| xferTarget | input | ADDR_W | Branch/jump destination |
| linkAddr | input | ADDR_W | Return address of a call |
| rangeWrEn | input | 1 | Request to load the trusted range |
| rangeWrStart | input | ADDR_W | New inclusive start of the range |
| rangeWrEnd | input | ADDR_W | New exclusive end of the range |
| domKernel | output | 1 | Instruction is kernel code |
| domTrusted | output | 1 | Instruction is trusted user code |
| domUntrusted | output | 1 | Instruction is untrusted user code |
| cfFault | output | 1 | Illegal control transfer from untrusted code |
| cfCause | output | 4 | Fault cause, 4'hE on fault |
| retPulse | output | 1 | Legal return to trusted code |

## Verification
A corrupted range register shows up on the domain outputs of the very next checked user instruction near a range edge, so the bench probes PCs at start-1, start, end-1 and end. A return register that is lost, written by untrusted code or not cleared stays hidden until the next untrusted branch. That branch then faults where a pulse was due, or pulses where a fault was due, in the same cycle it is presented. For this reason the bench always follows a rejected transfer, and also a legal return, with a second transfer to the stored address.

// File: rtl/code_domain_pkg.sv
package code_domain_pkg;
  typedef enum logic [1:0] {
    CLS_OTHER = 2'b00,
    CLS_LOAD  = 2'b01,
    CLS_STORE = 2'b10,
    CLS_XFER  = 2'b11
  } inst_class_e;

  localparam logic [3:0] CAUSE_RET_ERR = 4'hE;
  localparam logic [3:0] CAUSE_NONE    = 4'h0;

  typedef struct packed {
    logic rangeLoad;
    logic retCapture;
    logic retClear;
  } guard_strobe_t;
endpackage

// File: rtl/guard_datapath.sv
module guard_datapath
  import code_domain_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  guard_strobe_t     strobe,
  input  logic [ADDR_W-1:0] instPc,
  input  logic [ADDR_W-1:0] xferTarget,
  input  logic [ADDR_W-1:0] linkAddr,
  input  logic [ADDR_W-1:0] rangeWrStart,
  input  logic [ADDR_W-1:0] rangeWrEnd,
  output logic              pcInRange,
  output logic              targetInRange,
  output logic              retMatch,
  output logic              retValid,
  output logic [ADDR_W-1:0] retAddr,
  output logic [ADDR_W-1:0] rangeStart,
  output logic [ADDR_W-1:0] rangeEnd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rangeStart <= '0;
      rangeEnd   <= '0;
    end else if (strobe.rangeLoad) begin
      rangeStart <= rangeWrStart;
      rangeEnd   <= rangeWrEnd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      retValid <= 1'b0;
      retAddr  <= '0;
    end else if (strobe.retCapture) begin
      retValid <= 1'b1;
      retAddr  <= linkAddr;
    end else if (strobe.retClear) begin
      retValid <= 1'b0;
    end
  end

  assign pcInRange     = (instPc >= rangeStart) && (instPc < rangeEnd);
  assign targetInRange = (xferTarget >= rangeStart) && (xferTarget < rangeEnd);
  assign retMatch      = retValid && (xferTarget == retAddr);

  // R7: a clear leaves the register empty on the next cycle
  p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.retClear && !strobe.retCapture) |=> !retValid);
  // R6: a capture leaves a valid address equal to the link presented
  p_capture_loads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.retCapture |=> (retValid && retAddr == $past(linkAddr)));
endmodule

// File: rtl/guard_control.sv
module guard_control
  import code_domain_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instValid,
  input  logic          privKernel,
  input  logic [1:0]    instClass,
  input  logic          rangeWrEn,
  input  logic          pcInRange,
  input  logic          targetInRange,
  input  logic          retMatch,
  output guard_strobe_t strobe,
  output logic          domKernel,
  output logic          domTrusted,
  output logic          domUntrusted,
  output logic          cfFault,
  output logic [3:0]    cfCause,
  output logic          retPulse
);
  logic checked, isXfer;

  always_comb begin
    checked      = instValid && (instClass != CLS_OTHER);
    isXfer       = instClass == CLS_XFER;
    domKernel    = checked && privKernel;
    domTrusted   = checked && !privKernel && pcInRange;
    domUntrusted = checked && !privKernel && !pcInRange;
    retPulse     = domUntrusted && isXfer && retMatch;
    cfFault      = domUntrusted && isXfer && !retMatch;
    cfCause      = cfFault ? CAUSE_RET_ERR : CAUSE_NONE;
    strobe.rangeLoad  = rangeWrEn && privKernel;
    strobe.retCapture = domTrusted && isXfer && !targetInRange;
    strobe.retClear   = retPulse;
  end

  // R4: checked instructions fall in exactly one domain
  p_domain_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (instValid && instClass != CLS_OTHER) |-> $onehot({domKernel, domTrusted, domUntrusted}));
  // R2: unchecked instructions raise nothing
  p_unchecked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!instValid || instClass == CLS_OTHER) |->
      ({domKernel, domTrusted, domUntrusted, cfFault, retPulse} == 5'b0));
  // R3: kernel code never faults or pulses
  p_kernel_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (instValid && privKernel) |-> !(cfFault || retPulse));
  // R9: loads and stores never fault or pulse
  p_memop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (instClass != CLS_XFER) |-> !(cfFault || retPulse));
  // R8: fault carries the cause code
  p_fault_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfFault |-> (cfCause == 4'hE && !retPulse));
endmodule

// File: rtl/code_domain_guard.sv
module code_domain_guard
  import code_domain_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instValid,
  input  logic [ADDR_W-1:0] instPc,
  input  logic              privKernel,
  input  logic [1:0]        instClass,
  input  logic [ADDR_W-1:0] xferTarget,
  input  logic [ADDR_W-1:0] linkAddr,
  input  logic              rangeWrEn,
  input  logic [ADDR_W-1:0] rangeWrStart,
  input  logic [ADDR_W-1:0] rangeWrEnd,
  output logic              domKernel,
  output logic              domTrusted,
  output logic              domUntrusted,
  output logic              cfFault,
  output logic [3:0]        cfCause,
  output logic              retPulse
);
  guard_strobe_t     strobe;
  logic              pcInRange, targetInRange, retMatch, retValid;
  logic [ADDR_W-1:0] retAddr, rangeStart, rangeEnd;

  guard_control u_ctrl (
    .clk(clk), .rst_n(rst_n), .instValid(instValid), .privKernel(privKernel),
    .instClass(instClass), .rangeWrEn(rangeWrEn), .pcInRange(pcInRange),
    .targetInRange(targetInRange), .retMatch(retMatch), .strobe(strobe),
    .domKernel(domKernel), .domTrusted(domTrusted), .domUntrusted(domUntrusted),
    .cfFault(cfFault), .cfCause(cfCause), .retPulse(retPulse)
  );

  guard_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .instPc(instPc),
    .xferTarget(xferTarget), .linkAddr(linkAddr), .rangeWrStart(rangeWrStart),
    .rangeWrEnd(rangeWrEnd), .pcInRange(pcInRange), .targetInRange(targetInRange),
    .retMatch(retMatch), .retValid(retValid), .retAddr(retAddr),
    .rangeStart(rangeStart), .rangeEnd(rangeEnd)
  );

  // R5: user-mode range writes leave the range untouched
  p_range_kernel_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rangeWrEn && !privKernel) |=> ($stable(rangeStart) && $stable(rangeEnd)));
  // R8: a rejected transfer does not alter the return register
  p_fault_keeps_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfFault |=> ($stable(retValid) && $stable(retAddr)));
  // R7: a legal return invalidates the register
  p_return_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retPulse |=> !retValid);
endmodule

// File: tb/tb_code_domain_guard.sv
module tb_code_domain_guard;
  localparam int  ADDR_W = 32;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic instValid = 1'b0, privKernel = 1'b0, rangeWrEn = 1'b0;
  logic [1:0] instClass = 2'b00;
  logic [ADDR_W-1:0] instPc = '0, xferTarget = '0, linkAddr = '0, rangeWrStart = '0, rangeWrEnd = '0;
  logic domKernel, domTrusted, domUntrusted, cfFault, retPulse;
  logic [3:0] cfCause;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [ADDR_W-1:0] mStart = '0, mEnd = '0, mRet = '0;
  logic mRetValid = 1'b0;

  code_domain_guard #(.ADDR_W(ADDR_W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic bit inRng(logic [ADDR_W-1:0] a);
    return (a >= mStart) && (a < mEnd);
  endfunction

  // packed expectation {kernel, trusted, untrusted, fault, cause[3:0], pulse}
  function automatic logic [8:0] expOut();
    bit chk, ker, tru, unt, flt, pul;
    chk = instValid && instClass != 2'b00;
    ker = chk && privKernel;
    tru = chk && !privKernel && inRng(instPc);
    unt = chk && !privKernel && !inRng(instPc);
    pul = unt && instClass == 2'b11 && mRetValid && xferTarget == mRet;
    flt = unt && instClass == 2'b11 && !pul;
    return {ker, tru, unt, flt, (flt ? 4'hE : 4'h0), pul};
  endfunction

  function automatic string autoTag();
    if (!instValid || instClass == 2'b00) return "R2";
    if (privKernel) return "R3";
    if (inRng(instPc)) return (instClass == 2'b11) ? "R6" : "R4";
    if (instClass != 2'b11) return "R9";
    return (mRetValid && xferTarget == mRet) ? "R7" : "R8";
  endfunction

  task automatic step(string tagIn);
    logic [8:0] e, a;
    string t;
    #1;
    e = expOut();
    a = {domKernel, domTrusted, domUntrusted, cfFault, cfCause, retPulse};
    t = (tagIn == "") ? autoTag() : tagIn;
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s pc=%h cls=%b tgt=%h actual=%b expected=%b", t, instPc, instClass, xferTarget, a, e);
    end
    @(posedge clk);
    if (rangeWrEn && privKernel) begin mStart = rangeWrStart; mEnd = rangeWrEnd; end
    if (instValid && instClass == 2'b11 && !privKernel) begin
      if (inRng(instPc) && !inRng(xferTarget)) begin mRetValid = 1'b1; mRet = linkAddr; end
      else if (!inRng(instPc) && mRetValid && xferTarget == mRet) mRetValid = 1'b0;
    end
    @(negedge clk);
    rangeWrEn = 1'b0;
  endtask

  task automatic inst(logic k, logic [1:0] c, logic [ADDR_W-1:0] pc,
                      logic [ADDR_W-1:0] tg, logic [ADDR_W-1:0] ln, string tagIn);
    instValid = 1'b1; privKernel = k; instClass = c; instPc = pc;
    xferTarget = tg; linkAddr = ln;
    step(tagIn);
  endtask

  task automatic writeRange(logic k, logic [ADDR_W-1:0] s, logic [ADDR_W-1:0] e2);
    instValid = 1'b0; instClass = 2'b00; privKernel = k;
    rangeWrEn = 1'b1; rangeWrStart = s; rangeWrEnd = e2;
    step("R5");
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    inst(0, 2'b01, 32'h0, 0, 0, "R1");              // R1 empty range
    inst(0, 2'b11, 32'h40, 32'h10, 32'h44, "R1");   // R1 no valid return: fault
    inst(1, 2'b00, 32'h40, 0, 0, "R2");
    instValid = 1'b0; instClass = 2'b11; step("R2");
    writeRange(0, 32'h40, 32'h80);                  // R5 user write ignored
    inst(0, 2'b01, 32'h40, 0, 0, "R5");
    writeRange(1, 32'h40, 32'h80);                  // R5 kernel write takes effect
    inst(0, 2'b01, 32'h40, 0, 0, "R4");
    inst(0, 2'b10, 32'h7F, 0, 0, "R4");
    inst(0, 2'b01, 32'h80, 0, 0, "R4");
    inst(0, 2'b10, 32'h3F, 0, 0, "R4");
    inst(1, 2'b11, 32'h200, 32'h999, 0, "R3");
    inst(0, 2'b11, 32'h50, 32'h60, 32'h54, "R6");   // inside target: no capture
    inst(0, 2'b11, 32'h100, 32'h54, 0, "R6");       // must fault
    inst(0, 2'b11, 32'h58, 32'h100, 32'h5C, "R6");  // capture 5C
    inst(0, 2'b10, 32'h104, 0, 0, "R9");
    inst(0, 2'b11, 32'h108, 32'h99, 32'h77, "R8");  // mismatch, ret unchanged
    inst(0, 2'b11, 32'h10C, 32'h5C, 0, "R8");       // still returns legally
    inst(0, 2'b11, 32'h100, 32'h5C, 0, "R7");       // now invalid: fault

    for (int i = 0; i < 4000; i++) begin
      logic [1:0] c;
      logic [ADDR_W-1:0] pc, tg;
      if ($urandom % 50 == 0) begin
        writeRange($urandom % 2, $urandom % 256, $urandom % 256);
      end else begin
        c  = 2'($urandom);
        pc = 32'($urandom % 256);
        tg = ($urandom % 3 == 0) ? mRet : 32'($urandom % 256);
        instValid = ($urandom % 8) != 0;
        privKernel = ($urandom % 6) == 0;
        instClass = c; instPc = pc; xferTarget = tg;
        linkAddr = 32'($urandom % 256);
        step("");
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule